// File: doc/BRIEF.md
# Edge-Triggered Wakeup and Interrupt Capture Unit

This block watches eight input pins for transitions and records them in a pending register. Each pin has its own enable bit, which lets it raise a request. It also has its own edge-select bit, which picks the rising or the falling transition. A selected transition sets the pin's pending bit, whether or not the pin is enabled. When any pending bit is also enabled, the unit raises a request. The request is an interrupt while the core runs and a wakeup while the sleep flag is high.

Software reaches the block through a small register port. The enable and edge-select registers are plain writable registers. The pending register has no plain write. It is accessed by exchange: in the write cycle the old contents appear on the read data, and the written value replaces them at the clock edge. Writing zero clears it. A pin edge that lands in the same cycle as an exchange is kept, so a clearing exchange never loses an event.

The pins are synchronized into the clock domain before edge detection. Detection compares the current synchronized sample with the previous one.

Top module: `pinwake_ctrl`

## Requirements
- R1: After reset, the enable, edge-select and pending registers read zero, and the interrupt and wakeup requests are low.
- R2: With edge-select bit 0, a low-to-high change on a pin sets its pending bit. A pin change set up before clock edge E0 is visible in the pending register after edge E2, and not after E1.
- R3: With edge-select bit 1, a high-to-low change sets the pending bit. A transition of the other direction sets nothing.
- R4: Pending bits capture on disabled pins too. Enabling a pin whose pending bit is already set raises a request with no new edge.
- R5: A pending bit stays set until an exchange writes it to zero. Later pin activity does not clear it.
- R6: Select code 2 is the pending register. During an exchange cycle the read data shows the old pending value. The written value is loaded at that clock edge, and a write of zero clears every bit.
- R7: If a pin edge is recorded in the same cycle as an exchange write, that pin's bit is set after the exchange, even when the written value has it at zero.
- R8: The interrupt request is high exactly when sleep is low and some pending bit is also enabled. The wakeup request is high exactly when sleep is high under the same condition. The two are never high together.
- R9: Select code 0 writes and reads the enable register and code 1 the edge-select register. Code 3 reads zero, and a write to it changes nothing.
- R10: Neither the pin level present when reset is released nor a change of edge-select bits sets any pending bit.
- R11: A pin pulse that lasts one clock period and spans one rising clock edge is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 8 | Monitored pins, asynchronous to the clock |
| sleep_i | input | 1 | High while the core is in its low-power state |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 edge select, 2 pending (exchange), 3 unused |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register, combinational |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions assume the write strobe, the select and the write data hold known values from the first clock. They also assume a pending bit can only fall in the cycle after an exchange. A pin that toggles faster than the synchronizer can follow would break the capture timing the bench relies on. The stimulus therefore changes every input only on the falling clock edge and holds each pin level for at least one full period. It also waits several cycles after each pin change, so every edge has passed the synchronizer before the next one arrives. The same-cycle exchange case is set up by counting clock edges from the pin change to the cycle in which the edge is detected.

// File: rtl/pinwake_pkg.sv
package pinwake_pkg;

  // Register select codes used on the register port
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_EDGE   = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_NONE   = 2'd3
  } wk_sel_e;

endpackage

// File: rtl/pinwake_rstsync.sv
module pinwake_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pinwake_sync.sv
module pinwake_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pinwake_edge.sv
module pinwake_edge #(
  parameter int W        = 8,
  parameter int ARM_CYCS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] hit_o
);

  logic [W-1:0]        prev_q;
  logic [ARM_CYCS-1:0] arm_q;
  logic [ARM_CYCS-1:0] arm_d;
  logic                armed;

  // Detection stays off until the previous-sample register holds a real
  // pin sample, so the reset value never looks like a transition.
  always_comb begin
    arm_d = {arm_q[ARM_CYCS-2:0], 1'b1};
  end

  assign armed = arm_q[ARM_CYCS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      prev_q <= '0;
    end else begin
      arm_q  <= arm_d;
      prev_q <= smp_i;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise;
    logic fall;
    assign rise     = ~prev_q[b] &  smp_i[b];
    assign fall     =  prev_q[b] & ~smp_i[b];
    assign hit_o[b] = armed & (fall_sel_i[b] ? fall : rise);
  end

endmodule

// File: rtl/pinwake_pend.sv
module pinwake_pend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xchg_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic [W-1:0] base;

  // New edges are merged after the exchanged value: a set beats a clear.
  always_comb begin
    base   = xchg_i ? wdata_i : pend_q;
    pend_d = base | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/pinwake_ctrl.sv
module pinwake_ctrl #(
  parameter int NPINS      = 8,
  parameter int SYNC_STG   = 2,
  parameter int RST_STG    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             sleep_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [NPINS-1:0] reg_wdata_i,
  output logic [NPINS-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             wake_o
);

  import pinwake_pkg::*;

  localparam int ARM_CYCS = SYNC_STG + 1;

  logic             rst_sync_n;
  logic [NPINS-1:0] pin_smp;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] en_d;
  logic [NPINS-1:0] edg_q;
  logic [NPINS-1:0] edg_d;
  logic             en_ce;
  logic             edg_ce;
  logic             xchg;
  logic             any_req;
  wk_sel_e          sel;

  assign sel = wk_sel_e'(reg_sel_i);

  pinwake_rstsync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pinwake_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pins_i),
    .dout  (pin_smp)
  );

  pinwake_edge #(.W(NPINS), .ARM_CYCS(ARM_CYCS)) u_edge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .smp_i      (pin_smp),
    .fall_sel_i (edg_q),
    .hit_o      (hit)
  );

  pinwake_pend #(.W(NPINS)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .xchg_i  (xchg),
    .wdata_i (reg_wdata_i),
    .hit_i   (hit),
    .pend_o  (pend_q)
  );

  // Configuration registers: decode and clock enables
  always_comb begin
    en_ce  = reg_we_i && (sel == SEL_ENABLE);
    edg_ce = reg_we_i && (sel == SEL_EDGE);
    xchg   = reg_we_i && (sel == SEL_PEND);
    en_d   = reg_wdata_i;
    edg_d  = reg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= '0;
      edg_q <= '0;
    end else begin
      if (en_ce) begin
        en_q <= en_d;
      end
      if (edg_ce) begin
        edg_q <= edg_d;
      end
    end
  end

  // Read mux: the pending value shown in an exchange cycle is the old one
  always_comb begin
    unique case (sel)
      SEL_ENABLE: reg_rdata_o = en_q;
      SEL_EDGE:   reg_rdata_o = edg_q;
      SEL_PEND:   reg_rdata_o = pend_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  // Request steering
  always_comb begin
    any_req = |(pend_q & en_q);
    irq_o   = any_req & ~sleep_i;
    wake_o  = any_req &  sleep_i;
  end

endmodule

// File: rtl/pinwake_chk.sv
module pinwake_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep_i,
  input logic         reg_we_i,
  input logic [1:0]   reg_sel_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] en_q,
  input logic [W-1:0] pend_q,
  input logic         irq_o,
  input logic         wake_o
);

  // R8: interrupt and wakeup never together
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && wake_o));

  // R8: wakeup only while asleep
  a_r8_wake_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);

  // R8: a request needs an enabled pending bit
  a_r8_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || wake_o) |-> ((pend_q & en_q) != '0));

  // R5: pending bits fall only after an exchange write
  a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(reg_we_i) && ($past(reg_sel_i) == 2'd2))
      |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R9: a write to select 0 loads the enable register
  a_r9_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && (reg_sel_i == 2'd0)) |=> (en_q == $past(reg_wdata_i)));

endmodule

bind pinwake_ctrl pinwake_chk #(.W(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sleep_i     (sleep_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .en_q        (en_q),
  .pend_q      (pend_q),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/pinwake_ctrl_tb.sv
module pinwake_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] pins;
  logic       sleep;
  logic       we;
  logic [1:0] sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;
  logic       wake;

  int checks = 0;
  int errors = 0;

  pinwake_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .sleep_i     (sleep),
    .reg_we_i    (we),
    .reg_sel_i   (sel),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {enable, edge_sel, pins_before, pins_after, exp_pend, sleep, exp_irq, exp_wake}
  localparam logic [42:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 8'h00, 8'hF0, 8'hF0, 1'b0, 1'b0, 1'b0},
    {8'hFF, 8'hFF, 8'hFF, 8'h5A, 8'hA5, 1'b0, 1'b1, 1'b0},
    {8'h0F, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0},
    {8'h3C, 8'h0F, 8'h0F, 8'hF0, 8'hFF, 1'b1, 1'b0, 1'b1},
    {8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; pins = 8'h00; sleep = 1'b0; we = 1'b0; sel = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(2'd0, r); chk("R1 enable", r, 8'h00);
    rd(2'd1, r); chk("R1 edge", r, 8'h00);
    rd(2'd2, r); chk("R1 pending", r, 8'h00);
    chk("R1 irq/wake", {6'd0, irq, wake}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // Table walk: R2, R3, R4, R8
    for (int i = 0; i < 6; i++) begin
      logic [42:0] v;
      v = VEC[i];
      sleep = 1'b0;
      wr(2'd0, v[42:35]);
      wr(2'd1, v[34:27]);
      pins = v[26:19];
      repeat (4) @(negedge clk);
      wr(2'd2, 8'h00);
      pins = v[18:11];
      repeat (4) @(negedge clk);
      sleep = v[2];
      rd(2'd2, r); chk($sformatf("R2/R3/R4 vec%0d pending", i), r, v[10:3]);
      chk($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, v[1]});
      chk($sformatf("R8 vec%0d wake", i), {7'd0, wake}, {7'd0, v[0]});
    end
    sleep = 1'b0;

    // R4: stale pending bit raises a request once enabled
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); pins = 8'h00;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h00);
    pins = 8'h10;
    repeat (4) @(negedge clk);
    chk("R4 disabled no irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h10);
    #1 chk("R4 enable stale irq", {7'd0, irq}, 8'h01);
    sleep = 1'b1; #1;
    chk("R8 sleep wake", {6'd0, irq, wake}, 8'h01);
    sleep = 1'b0;

    // R5: sticky through opposite pin activity
    pins = 8'h00;
    repeat (5) @(negedge clk);
    rd(2'd2, r); chk("R5 sticky", r, 8'h10);

    // R2: exact latency from pin change
    wr(2'd2, 8'h00);
    pins = 8'h20;
    @(negedge clk); @(negedge clk);
    rd(2'd2, r); chk("R2 not after E1", r, 8'h00);
    @(negedge clk);
    rd(2'd2, r); chk("R2 set after E2", r, 8'h20);

    // R6 and R7: exchange returns old value; same-cycle edge wins
    wr(2'd2, 8'h02);
    pins = 8'h21;
    @(negedge clk); @(negedge clk);
    we = 1'b1; sel = 2'd2; wdata = 8'h00;
    #1 chk("R6 exchange old value", rdata, 8'h02);
    @(negedge clk); we = 1'b0;
    rd(2'd2, r); chk("R7 set beats clear", r, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, r); chk("R6 write zero clears", r, 8'h00);

    // R9: select 3 reads zero and ignores writes
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    wr(2'd3, 8'hFF);
    rd(2'd0, r); chk("R9 enable", r, 8'hA5);
    rd(2'd1, r); chk("R9 edge", r, 8'h3C);
    rd(2'd2, r); chk("R9 pending untouched", r, 8'h00);
    rd(2'd3, r); chk("R9 sel3 zero", r, 8'h00);

    // R10: edge-select change creates no capture
    wr(2'd1, 8'h00); pins = 8'hFF;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF); wr(2'd1, 8'h00);
    repeat (4) @(negedge clk);
    rd(2'd2, r); chk("R10 edge select change", r, 8'h00);

    // R10: pin level at reset release
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd2, r); chk("R10 reset with pins high", r, 8'h00);

    // R11: one-period pulse
    pins = 8'h00;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h00);
    pins = 8'h04;
    @(negedge clk); pins = 8'h00;
    repeat (4) @(negedge clk);
    rd(2'd2, r); chk("R11 short pulse", r, 8'h04);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule